// File: doc/BRIEF.md
# Push-Button Frequency Synthesiser

This block makes a square wave whose frequency in kilohertz is the value of an 8-bit setpoint register. Two push-buttons move the setpoint, one up and one down. A short press moves it by exactly one. A press held past a long-hold threshold (one second by default) keeps stepping the value at a fixed repeat rate (100 ms by default) until the button is let go. The setpoint is always driven on an 8-bit indicator bus as plain binary, so a row of LEDs shows the current frequency.

Each raw button passes through a synchroniser chain and a stability filter before any edge is acted on. A phase accumulator clocked by the system clock adds a step proportional to the setpoint on every cycle, and its top bit gives the output. All timer lengths are parameters derived from the system clock rate, so a bench or a slower board can shorten them.

Top module: `pulse_gen_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) leaves the setpoint at 0, `wave_out` low and both button timers idle.
- R2: `led` always shows the setpoint as an unsigned binary number, bit 0 being the least significant.
- R3: An up press held stable for at least `DEB_CYC` cycles raises the setpoint by exactly one, no later than `DEB_CYC`+4 cycles after the press starts.
- R4: A down press held stable for at least `DEB_CYC` cycles lowers the setpoint by exactly one.
- R5: A button pulse shorter than `DEB_CYC` cycles leaves the setpoint unchanged.
- R6: After the first step, a press still held `HOLD_CYC` cycles later produces a second step, then one more step every `REPEAT_CYC` cycles until release.
- R7: The setpoint stops at 255 when rising and at 0 when falling; it never wraps.
- R8: While both filtered button levels are high, the setpoint does not change.
- R9: While the setpoint is 0, `wave_out` stays low.
- R10: For a non-zero setpoint N, `wave_out` has N*1000 rising edges per second of clock time, within one edge of the measuring window, with a duty of about 50%.
- R11: The setpoint never moves by more than one unit in a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Raw increment button, active high, asynchronous |
| btn_dn | input | 1 | Raw decrement button, active high, asynchronous |
| led | output | 8 | Current setpoint in binary (kHz) |
| wave_out | output | 1 | Rectangular output at the setpoint frequency |

## Verification
The hardest states to reach from the ports are the two ends of the setpoint range under automatic repeat, because 255 single presses would take too long. The bench shortens the filter, hold and repeat counts through parameters, keeps one button down for tens of thousands of cycles so the repeat runs into the ceiling and then the floor, and checks that further steps have no effect there. Frequency is checked by counting rising edges and high cycles over a window long enough to hold many periods.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
   // Per-button repeat sequencer state
   typedef enum logic [1:0] {
      RPT_IDLE = 2'd0,
      RPT_HOLD = 2'd1,
      RPT_RUN  = 2'd2
   } rpt_state_t;

   // Index of each button inside the per-button arrays
   localparam int BTN_UP = 0;
   localparam int BTN_DN = 1;
   localparam int N_BTN  = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pg_btn_cond.sv
module pg_btn_cond
   import pgen_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYC     = 500_000,
   parameter int HOLD_CYC    = 50_000_000,
   parameter int REPEAT_CYC  = 5_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic level,
   output logic step
);
   localparam int DW = $clog2(DEB_CYC + 1);
   localparam int TW = $clog2(max2(HOLD_CYC, REPEAT_CYC) + 1);
   localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_CYC - 1);
   localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] REP_LAST  = TW'(REPEAT_CYC - 1);

   logic [SYNC_STAGES-1:0] chain;
   logic                   s_in;
   logic [DW-1:0]          deb_cnt;
   logic                   lvl_q, lvl_prev;
   logic                   rise;
   rpt_state_t             st_q, st_d;
   logic [TW-1:0]          tmr_q, tmr_d;
   logic                   fire;

   // Synchroniser chain, length chosen by parameter
   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], btn_raw};
   end
   assign s_in = chain[SYNC_STAGES-1];

   // Stability filter: the level follows the input only after DEB_CYC
   // consecutive cycles of disagreement
   always_ff @(posedge clk) begin
      if (rst) begin
         deb_cnt  <= '0;
         lvl_q    <= 1'b0;
         lvl_prev <= 1'b0;
      end else begin
         lvl_prev <= lvl_q;
         if (s_in == lvl_q) begin
            deb_cnt <= '0;
         end else if (deb_cnt == DEB_LAST) begin
            deb_cnt <= '0;
            lvl_q   <= s_in;
         end else begin
            deb_cnt <= deb_cnt + 1'b1;
         end
      end
   end
   assign rise = lvl_q & ~lvl_prev;

   // Long-hold and repeat sequencer
   always_comb begin
      st_d  = st_q;
      tmr_d = tmr_q;
      fire  = 1'b0;
      case (st_q)
         RPT_IDLE: begin
            tmr_d = '0;
            if (rise) begin
               fire = 1'b1;
               st_d = RPT_HOLD;
            end
         end
         RPT_HOLD: begin
            if (!lvl_q) begin
               st_d  = RPT_IDLE;
               tmr_d = '0;
            end else if (tmr_q == HOLD_LAST) begin
               fire  = 1'b1;
               st_d  = RPT_RUN;
               tmr_d = '0;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         RPT_RUN: begin
            if (!lvl_q) begin
               st_d  = RPT_IDLE;
               tmr_d = '0;
            end else if (tmr_q == REP_LAST) begin
               fire  = 1'b1;
               tmr_d = '0;
            end else begin
               tmr_d = tmr_q + 1'b1;
            end
         end
         default: begin
            st_d  = RPT_IDLE;
            tmr_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= RPT_IDLE;
         tmr_q <= '0;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
      end
   end

   assign level = lvl_q;
   assign step  = fire;
endmodule

// File: rtl/pg_setpoint.sv
module pg_setpoint #(
   parameter int SP_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            inc_step,
   input  logic            dec_step,
   input  logic            inc_lvl,
   input  logic            dec_lvl,
   output logic [SP_W-1:0] sp
);
   localparam logic [SP_W-1:0] SP_MAX = {SP_W{1'b1}};

   logic do_inc, do_dec;

   // A step counts only while the opposite button is released
   assign do_inc = inc_step & ~dec_lvl & (sp != SP_MAX);
   assign do_dec = dec_step & ~inc_lvl & (sp != '0);

   always_ff @(posedge clk) begin
      if (rst)         sp <= '0;
      else if (do_inc) sp <= sp + 1'b1;
      else if (do_dec) sp <= sp - 1'b1;
   end
endmodule

// File: rtl/pg_phase.sv
module pg_phase #(
   parameter int SP_W    = 8,
   parameter int ACC_W   = 32,
   parameter int CLK_HZ  = 50_000_000,
   parameter int UNIT_HZ = 1000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [SP_W-1:0] sp,
   output logic            wave
);
   // Accumulator increment for one setpoint unit, rounded to nearest
   localparam logic [63:0] STEP64 =
      ((64'(UNIT_HZ) << ACC_W) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
   localparam logic [ACC_W-1:0] UNIT_STEP = STEP64[ACC_W-1:0];

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] inc;

   assign inc = ACC_W'(sp) * UNIT_STEP;

   always_ff @(posedge clk) begin
      if (rst || sp == '0) begin
         acc  <= '0;
         wave <= 1'b0;
      end else begin
         acc  <= acc + inc;
         wave <= acc[ACC_W-1];
      end
   end
endmodule

// File: rtl/pulse_gen_top.sv
module pulse_gen_top
   import pgen_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int UNIT_HZ     = 1000,
   parameter int SP_W        = 8,
   parameter int ACC_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYC     = CLK_HZ / 100,
   parameter int HOLD_CYC    = CLK_HZ,
   parameter int REPEAT_CYC  = CLK_HZ / 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            btn_up,
   input  logic            btn_dn,
   output logic [SP_W-1:0] led,
   output logic            wave_out
);
   localparam int SP_TOP = (1 << SP_W) - 1;

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pulse_gen_top: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYC < 2 || HOLD_CYC < 2 || REPEAT_CYC < 2) begin : g_bad_tmr
      $error("pulse_gen_top: timer lengths must be at least 2 cycles");
   end
   if (ACC_W < SP_W + 4 || ACC_W > 48) begin : g_bad_acc
      $error("pulse_gen_top: ACC_W out of range");
   end
   if (CLK_HZ / 2 <= UNIT_HZ * SP_TOP) begin : g_bad_clk
      $error("pulse_gen_top: clock too slow for top setpoint");
   end

   logic [N_BTN-1:0] raw;
   logic [N_BTN-1:0] btn_lvl;
   logic [N_BTN-1:0] btn_step;
   logic [SP_W-1:0]  sp;

   assign raw[BTN_UP] = btn_up;
   assign raw[BTN_DN] = btn_dn;

   for (genvar b = 0; b < N_BTN; b++) begin : g_btn
      pg_btn_cond #(
         .SYNC_STAGES (SYNC_STAGES),
         .DEB_CYC     (DEB_CYC),
         .HOLD_CYC    (HOLD_CYC),
         .REPEAT_CYC  (REPEAT_CYC)
      ) u_cond (
         .clk     (clk),
         .rst     (rst),
         .btn_raw (raw[b]),
         .level   (btn_lvl[b]),
         .step    (btn_step[b])
      );
   end

   pg_setpoint #(.SP_W(SP_W)) u_sp (
      .clk      (clk),
      .rst      (rst),
      .inc_step (btn_step[BTN_UP]),
      .dec_step (btn_step[BTN_DN]),
      .inc_lvl  (btn_lvl[BTN_UP]),
      .dec_lvl  (btn_lvl[BTN_DN]),
      .sp       (sp)
   );

   pg_phase #(
      .SP_W    (SP_W),
      .ACC_W   (ACC_W),
      .CLK_HZ  (CLK_HZ),
      .UNIT_HZ (UNIT_HZ)
   ) u_phase (
      .clk  (clk),
      .rst  (rst),
      .sp   (sp),
      .wave (wave_out)
   );

   assign led = sp;
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker #(
   parameter int SP_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic [SP_W-1:0] led,
   input logic            wave,
   input logic            up_lvl,
   input logic            dn_lvl
);
   localparam logic [SP_W-1:0] TOP = {SP_W{1'b1}};
   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (led == '0 && !wave));

   assert_no_wrap_high_R7: assert property (@(posedge clk) disable iff (rst)
      (led == TOP) |=> (led != '0));

   assert_no_wrap_low_R7: assert property (@(posedge clk) disable iff (rst)
      (led == '0) |=> (led != TOP));

   assert_both_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      (up_lvl && dn_lvl) |=> $stable(led));

   assert_zero_silent_R9: assert property (@(posedge clk) disable iff (rst)
      (led == '0) |=> !wave);

   assert_unit_move_R11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((led == $past(led)) || (led == $past(led) + ONE) ||
                (led == $past(led) - ONE)));
endmodule

bind pulse_gen_top pgen_checker #(.SP_W(SP_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .led    (led),
   .wave   (wave_out),
   .up_lvl (btn_lvl[0]),
   .dn_lvl (btn_lvl[1])
);

// File: tb/tb_pulse_gen_top.sv
module tb_pulse_gen_top;
   localparam int CLK_HZ = 50_000_000;
   localparam int DEB    = 20;
   localparam int HOLD   = 400;
   localparam int REP    = 100;
   localparam int SETTLE = 60;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       btn_up = 1'b0;
   logic       btn_dn = 1'b0;
   logic [7:0] led;
   logic       wave_out;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;
   int jumps  = 0;
   logic [7:0] led_prev = 8'd0;

   always #10 clk = ~clk;

   pulse_gen_top #(
      .CLK_HZ     (CLK_HZ),
      .DEB_CYC    (DEB),
      .HOLD_CYC   (HOLD),
      .REPEAT_CYC (REP)
   ) dut (
      .clk      (clk),
      .rst      (rst),
      .btn_up   (btn_up),
      .btn_dn   (btn_dn),
      .led      (led),
      .wave_out (wave_out)
   );

   // Watch for any jump larger than one unit between samples (R11)
   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (!rst) begin
         if (!((led == led_prev) || (led == led_prev + 8'd1) ||
               (led == led_prev - 8'd1)))
            jumps <= jumps + 1;
      end
      led_prev <= led;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bit0 = up, bit1 = down
   task automatic press(input logic [1:0] b, input int hold);
      btn_up = b[0];
      btn_dn = b[1];
      repeat (hold) @(negedge clk);
      btn_up = 1'b0;
      btn_dn = 1'b0;
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic measure(input int n, output int rises, output int highs);
      logic last;
      rises = 0;
      highs = 0;
      last  = wave_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wave_out && !last) rises++;
         if (wave_out) highs++;
         last = wave_out;
      end
   endtask

   // {buttons[1:0], hold cycles[15:0], expected led[7:0]}
   localparam int NV = 10;
   localparam logic [25:0] VEC [NV] = '{
      {2'b01, 16'd100, 8'd1},   // R3 short up
      {2'b01, 16'd100, 8'd2},   // R3
      {2'b10, 16'd100, 8'd1},   // R4 short down
      {2'b10, 16'd100, 8'd0},   // R4
      {2'b10, 16'd100, 8'd0},   // R7 floor
      {2'b01, 16'd972, 8'd7},   // R6 hold: 1 + 1 + 5 repeats
      {2'b10, 16'd100, 8'd6},   // R4
      {2'b11, 16'd100, 8'd6},   // R8 both pressed
      {2'b01, 16'd8,   8'd6},   // R5 glitch
      {2'b10, 16'd972, 8'd0}    // R6/R7 hold down into floor
   };

   initial begin : watchdog
      while (cycles < 190_000) @(negedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin : main
      int r, h, exp_r;
      repeat (4) @(negedge clk);
      check(led == 8'd0 && wave_out == 1'b0, "R1 reset state", led, 0);
      rst = 1'b0;
      @(negedge clk);

      // R3 latency: step visible within DEB+4 cycles of a press
      btn_up = 1'b1;
      repeat (DEB + 4) @(negedge clk);
      check(led == 8'd1, "R3 step latency", led, 1);
      btn_up = 1'b0;
      repeat (SETTLE) @(negedge clk);
      press(2'b10, 100);
      check(led == 8'd0, "R4 back to zero", led, 0);

      for (int i = 0; i < NV; i++) begin
         press(VEC[i][25:24], int'(VEC[i][23:8]));
         check(led == VEC[i][7:0], $sformatf("R2/R3-R8 vector %0d", i),
               led, VEC[i][7:0]);
      end

      // R7 ceiling through auto-repeat
      press(2'b01, 30000);
      check(led == 8'd255, "R7 ceiling by repeat", led, 255);
      press(2'b01, 100);
      check(led == 8'd255, "R7 no wrap above 255", led, 255);

      // R10 frequency at 255 kHz over 20000 cycles
      measure(20000, r, h);
      exp_r = 20000 * 255 / (CLK_HZ / 1000);
      check(r >= exp_r - 2 && r <= exp_r + 2, "R10 edges at 255", r, exp_r);
      check(h >= 9800 && h <= 10200, "R10 duty at 255", h, 10000);

      // Down to the floor, then the output must stay quiet
      press(2'b10, 30000);
      check(led == 8'd0, "R7 floor by repeat", led, 0);
      measure(2000, r, h);
      check(h == 0, "R9 output low at zero", h, 0);

      // R6 repeat count: 1 + 1 + 8 steps
      press(2'b01, 1272);
      check(led == 8'd10, "R6 repeat count", led, 10);

      measure(40000, r, h);
      exp_r = 40000 * 10 / (CLK_HZ / 1000);
      check(r >= exp_r - 1 && r <= exp_r + 1, "R10 edges at 10", r, exp_r);
      check(h >= 19500 && h <= 20500, "R10 duty at 10", h, 20000);

      // R1 reset from a running state
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(led == 8'd0, "R1 reset clears setpoint", led, 0);
      check(wave_out == 1'b0, "R1 reset clears output", wave_out, 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);

      check(jumps == 0, "R11 single-unit moves", jumps, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule